// File: doc/BRIEF.md
# Twelve-Channel Doorbell Mailbox

This block is a shared-memory mailbox between a host processor and an embedded controller. Twelve channels each own a fixed outgoing window and a fixed incoming window in one data memory of 92 32-bit words. The host reaches the data memory and a small control region over a simple register bus. It fills a channel's outgoing window with word writes in ascending address order and then rings that channel's doorbell. It learns of replies through per-channel receive bits and one combined interrupt.

The remote side has a port addressed by channel number and word index, not by byte address. The block turns that pair into a memory word using a fixed table of window bases and lengths. Through this port the controller reads outgoing messages, writes incoming ones, acknowledges doorbells and posts receive events. The remote side sees the pending doorbells directly.

Outgoing window lengths in bytes, channels 0 to 11: 16, 32, 12, 24, 36, 16, 24, 24, 4, 16, 16, 4. These windows are packed from byte 0x000. Incoming window lengths in bytes: 16, 32, 4, 4, 4, 16, 4, 24, 16, 4, 16, 4. These windows are packed from byte 0x0E0. The largest incoming window is 32 bytes.

Top module: `msg_mailbox`

## Requirements
- R1: With `hostCtrlSel`=1, the exact byte offsets are mapped as follows. 0x00 reads the transmit-pending bits. 0x04 is doorbell-set (write-only). 0x74 is receive-clear (write-only). 0x78 reads the receive bits. Bit n belongs to channel n, and bits 31:12 read 0. Reads of any other offset, including 0x04 and 0x74, return 0. Writes to any other offset change nothing.
- R2: A host write to 0x04 sets transmit-pending bit n for each 1 in data bit n. Bits written as 0 leave their channel unchanged. `remTxPend` shows the transmit-pending bits one cycle after the write.
- R3: A `remAck` strobe with channel c in 0..11 clears transmit-pending bit c on the next edge. If a doorbell set of the same bit happens in the same cycle, the bit stays 1.
- R4: A `remPost` strobe with channel c in 0..11 sets receive bit c on the next edge. `hostIrq` is 1 exactly when any receive bit is 1.
- R5: A host write to 0x74 clears receive bit n for each 1 in data bit n. Bits written as 0 have no effect. If a post to the same channel happens in the same cycle, the bit stays 1.
- R6: With `hostCtrlSel`=0, `hostAddr[9:2]` selects a data word and `hostAddr[1:0]` is ignored. Words 0..91 can be written and read. Words at 92 and above ignore writes and read as 0. Host read data appears on `hostRdata` one cycle after the request and holds until the next host read.
- R7: `remRead` with channel c and index k returns, one cycle later on `remRdata`, the word at byte (sum of outgoing lengths of channels below c) + 4k. If k is at or past the window length in words, the result is 0.
- R8: `remWrite` with channel c and index k writes the word at byte 0x0E0 + (sum of incoming lengths of channels below c) + 4k. If k is at or past the window length in words, the write is ignored and neighbouring windows stay unchanged.
- R9: A channel number of 12 or above is ignored by every remote strobe: ack, post and write change nothing, and a read returns 0.
- R10: If the host and the remote port write the same data word in the same cycle, the host value is kept.
- R11: After reset, all transmit and receive bits are 0, `hostIrq` is 0, and every data word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request for this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostCtrlSel | input | 1 | 1 = control region, 0 = data memory |
| hostAddr | input | 10 | Byte address within the selected region |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid the cycle after a read |
| hostIrq | output | 1 | OR of all receive bits |
| remTxPend | output | 12 | Transmit-pending bit per channel |
| remAck | input | 1 | Single-cycle doorbell acknowledge |
| remAckChan | input | 4 | Channel being acknowledged |
| remPost | input | 1 | Single-cycle receive event |
| remPostChan | input | 4 | Channel receiving the event |
| remChan | input | 4 | Channel for a remote window access |
| remWordIdx | input | 4 | Word index inside the window |
| remRead | input | 1 | Read word of the outgoing window |
| remWrite | input | 1 | Write word of the incoming window |
| remWdata | input | 32 | Remote write data |
| remRdata | output | 32 | Remote read data, valid the cycle after a read |

## Verification
The assertions assume that ack and post strobes are sampled only on the edge where they are high, and that the channel fields can carry any 4-bit value, including the unused codes 12 to 15. The stimulus respects the strobe assumption by driving every input at the falling edge and releasing it one cycle later. It also deliberately sends unused channel codes and collisions in the same cycle: doorbell with ack, clear with post, and host write with remote write. Because the assertions guard each status bit separately, a random phase can let any mix of these events land in the same cycle.

// File: rtl/msg_mailbox_pkg.sv
package msg_mailbox_pkg;

  localparam int NUM_CH      = 12;
  localparam int CH_W        = 4;
  localparam int ADDR_W      = 10;
  localparam int DATA_W      = 32;
  localparam int DATA_WORDS  = 92;
  localparam int WORD_W      = $clog2(DATA_WORDS);
  localparam int IDX_W       = 4;
  localparam int RX_BASE_B   = 224;

  localparam logic [ADDR_W-1:0] OFS_TX_STS  = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_DB_SET  = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_RX_CLR  = 10'h074;
  localparam logic [ADDR_W-1:0] OFS_RX_STS  = 10'h078;

  function automatic int txBytes(input int ch);
    case (ch)
      0: return 16;  1: return 32;  2: return 12;  3: return 24;
      4: return 36;  5: return 16;  6: return 24;  7: return 24;
      8: return 4;   9: return 16; 10: return 16; 11: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int rxBytes(input int ch);
    case (ch)
      0: return 16;  1: return 32;  2: return 4;   3: return 4;
      4: return 4;   5: return 16;  6: return 4;   7: return 24;
      8: return 16;  9: return 4;  10: return 16; 11: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int txBaseWord(input int ch);
    int s;
    s = 0;
    for (int i = 0; i < NUM_CH; i++)
      if (i < ch) s += txBytes(i) / 4;
    return s;
  endfunction

  function automatic int rxBaseWord(input int ch);
    int s;
    s = RX_BASE_B / 4;
    for (int i = 0; i < NUM_CH; i++)
      if (i < ch) s += rxBytes(i) / 4;
    return s;
  endfunction

  typedef struct packed {
    logic              hostRdLoad;
    logic              hostRdFromMem;
    logic              hostMemWe;
    logic [WORD_W-1:0] hostWord;
    logic [DATA_W-1:0] regVal;
    logic              remRdLoad;
    logic              remRdFromMem;
    logic [WORD_W-1:0] remRdWord;
    logic              remMemWe;
    logic [WORD_W-1:0] remWrWord;
  } mboxStrobes_t;

endpackage

// File: rtl/msg_mailbox_ctrl.sv
module msg_mailbox_ctrl
  import msg_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic              hostCtrlSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              remAck,
  input  logic [CH_W-1:0]   remAckChan,
  input  logic              remPost,
  input  logic [CH_W-1:0]   remPostChan,
  input  logic [CH_W-1:0]   remChan,
  input  logic [IDX_W-1:0]  remWordIdx,
  input  logic              remRead,
  input  logic              remWrite,
  output mboxStrobes_t      strobes,
  output logic [NUM_CH-1:0] txPend,
  output logic              irq
);

  localparam int HOST_IDX_W = ADDR_W - 2;

  logic [NUM_CH-1:0] txStsQ;
  logic [NUM_CH-1:0] rxStsQ;
  logic [NUM_CH-1:0] dbSet;
  logic [NUM_CH-1:0] rxClr;
  logic [NUM_CH-1:0] ackHit;
  logic [NUM_CH-1:0] postHit;
  logic              ctrlWr;
  logic              hostRd;
  logic [HOST_IDX_W-1:0] hostIdx;
  logic              hostIdxOk;
  logic              remChanOk;
  logic [DATA_W-1:0] regMux;

  assign ctrlWr    = hostValid && hostWrite && hostCtrlSel;
  assign hostRd    = hostValid && !hostWrite;
  assign hostIdx   = hostAddr[ADDR_W-1:2];
  assign hostIdxOk = int'(hostIdx) < DATA_WORDS;
  assign remChanOk = int'(remChan) < NUM_CH;

  assign dbSet = (ctrlWr && hostAddr == OFS_DB_SET) ? hostWdata[NUM_CH-1:0] : '0;
  assign rxClr = (ctrlWr && hostAddr == OFS_RX_CLR) ? hostWdata[NUM_CH-1:0] : '0;

  // Per-channel status bits; a set in the same cycle as a clear wins.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    assign ackHit[n]  = remAck  && (remAckChan  == CH_W'(n));
    assign postHit[n] = remPost && (remPostChan == CH_W'(n));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        txStsQ[n] <= 1'b0;
        rxStsQ[n] <= 1'b0;
      end else begin
        if (dbSet[n])       txStsQ[n] <= 1'b1;
        else if (ackHit[n]) txStsQ[n] <= 1'b0;
        if (postHit[n])     rxStsQ[n] <= 1'b1;
        else if (rxClr[n])  rxStsQ[n] <= 1'b0;
      end
    end

    AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (hostValid && hostWrite && hostCtrlSel && hostAddr == OFS_DB_SET && hostWdata[n])
      |=> txPend[n]); // R2

    AST_TX_DROP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
      $fell(txPend[n]) |-> $past(remAck && remAckChan == CH_W'(n))); // R3

    AST_RX_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rxStsQ[n]) |-> $past(hostValid && hostWrite && hostCtrlSel
                                  && hostAddr == OFS_RX_CLR && hostWdata[n])); // R5
  end

  assign txPend = txStsQ;
  assign irq    = |rxStsQ;

  always_comb begin
    regMux = '0;
    if (hostAddr == OFS_TX_STS)      regMux[NUM_CH-1:0] = txStsQ;
    else if (hostAddr == OFS_RX_STS) regMux[NUM_CH-1:0] = rxStsQ;
  end

  always_comb begin
    strobes               = '0;
    strobes.hostRdLoad    = hostRd;
    strobes.hostRdFromMem = hostRd && !hostCtrlSel && hostIdxOk;
    strobes.hostMemWe     = hostValid && hostWrite && !hostCtrlSel && hostIdxOk;
    strobes.hostWord      = WORD_W'(hostIdx);
    strobes.regVal        = (hostRd && hostCtrlSel) ? regMux : '0;
    strobes.remRdLoad     = remRead;
    strobes.remRdFromMem  = remRead && remChanOk
                            && int'(remWordIdx) < txBytes(int'(remChan)) / 4;
    strobes.remRdWord     = WORD_W'(txBaseWord(int'(remChan)) + int'(remWordIdx));
    strobes.remMemWe      = remWrite && remChanOk
                            && int'(remWordIdx) < rxBytes(int'(remChan)) / 4;
    strobes.remWrWord     = WORD_W'(rxBaseWord(int'(remChan)) + int'(remWordIdx));
  end

  AST_POST_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (remPost && int'(remPostChan) < NUM_CH) |=> irq); // R4

  AST_BAD_CHAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (remWrite && !remChanOk) |-> !strobes.remMemWe); // R9

endmodule

// File: rtl/msg_mailbox_data.sv
module msg_mailbox_data
  import msg_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobes_t      strobes,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] remWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] remRdata
);

  logic [DATA_W-1:0] mem [DATA_WORDS];
  logic [DATA_W-1:0] hostRdQ;
  logic [DATA_W-1:0] remRdQ;

  // Remote write first, host write last: host wins on a shared word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_WORDS; i++) mem[i] <= '0;
    end else begin
      if (strobes.remMemWe)  mem[strobes.remWrWord] <= remWdata;
      if (strobes.hostMemWe) mem[strobes.hostWord]  <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdQ <= '0;
      remRdQ  <= '0;
    end else begin
      if (strobes.hostRdLoad)
        hostRdQ <= strobes.hostRdFromMem ? mem[strobes.hostWord] : strobes.regVal;
      if (strobes.remRdLoad)
        remRdQ  <= strobes.remRdFromMem ? mem[strobes.remRdWord] : '0;
    end
  end

  assign hostRdata = hostRdQ;
  assign remRdata  = remRdQ;

  AST_REM_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.remRdLoad && !strobes.remRdFromMem) |=> remRdata == '0); // R7

  AST_HOST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.hostRdLoad |=> $stable(hostRdata)); // R6

endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import msg_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic              hostCtrlSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostIrq,
  output logic [NUM_CH-1:0] remTxPend,
  input  logic              remAck,
  input  logic [CH_W-1:0]   remAckChan,
  input  logic              remPost,
  input  logic [CH_W-1:0]   remPostChan,
  input  logic [CH_W-1:0]   remChan,
  input  logic [IDX_W-1:0]  remWordIdx,
  input  logic              remRead,
  input  logic              remWrite,
  input  logic [DATA_W-1:0] remWdata,
  output logic [DATA_W-1:0] remRdata
);

  mboxStrobes_t strobes;

  msg_mailbox_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostValid   (hostValid),
    .hostWrite   (hostWrite),
    .hostCtrlSel (hostCtrlSel),
    .hostAddr    (hostAddr),
    .hostWdata   (hostWdata),
    .remAck      (remAck),
    .remAckChan  (remAckChan),
    .remPost     (remPost),
    .remPostChan (remPostChan),
    .remChan     (remChan),
    .remWordIdx  (remWordIdx),
    .remRead     (remRead),
    .remWrite    (remWrite),
    .strobes     (strobes),
    .txPend      (remTxPend),
    .irq         (hostIrq)
  );

  msg_mailbox_data u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostWdata (hostWdata),
    .remWdata  (remWdata),
    .hostRdata (hostRdata),
    .remRdata  (remRdata)
  );

endmodule

// File: tb/msg_mailbox_bench.sv
`timescale 1ns/1ps
module msg_mailbox_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid, hostWrite, hostCtrlSel;
  logic [9:0]  hostAddr;
  logic [31:0] hostWdata, hostRdata;
  logic        hostIrq;
  logic [11:0] remTxPend;
  logic        remAck, remPost, remRead, remWrite;
  logic [3:0]  remAckChan, remPostChan, remChan, remWordIdx;
  logic [31:0] remWdata, remRdata;

  always #4 clk = ~clk;

  msg_mailbox u_msg_mailbox (.*);

  int total = 0;
  int failed = 0;
  int cyc = 0;
  string curTag = "R11";

  int txLen[12] = '{16, 32, 12, 24, 36, 16, 24, 24, 4, 16, 16, 4};
  int rxLen[12] = '{16, 32, 4, 4, 4, 16, 4, 24, 16, 4, 16, 4};
  int txB[12];
  int rxB[12];

  logic [11:0] mTx, mRx;
  logic [31:0] mMem[92];
  bit          expHostChk, expRemChk;
  logic [31:0] expHost, expRem;
  string       hostTag, remTag;

  initial begin
    txB[0] = 0;
    rxB[0] = 56;
    for (int i = 1; i < 12; i++) begin
      txB[i] = txB[i-1] + txLen[i-1] / 4;
      rxB[i] = rxB[i-1] + rxLen[i-1] / 4;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mTx = '0; mRx = '0;
      for (int i = 0; i < 92; i++) mMem[i] = '0;
      expHostChk = 0; expRemChk = 0;
    end else begin
      int w;
      logic [11:0] nTx, nRx;
      w = int'(hostAddr) / 4;
      expHostChk = hostValid && !hostWrite;
      if (expHostChk) begin
        hostTag = curTag;
        if (hostCtrlSel) begin
          if (hostAddr == 10'h000)      expHost = {20'h0, mTx};
          else if (hostAddr == 10'h078) expHost = {20'h0, mRx};
          else                          expHost = 0;
        end else expHost = (w < 92) ? mMem[w] : 32'h0;
      end
      expRemChk = remRead;
      if (remRead) begin
        remTag = curTag;
        expRem = 0;
        if (int'(remChan) < 12)
          if (int'(remWordIdx) < txLen[remChan] / 4) expRem = mMem[txB[remChan] + int'(remWordIdx)];
      end
      if (remWrite && int'(remChan) < 12)
        if (int'(remWordIdx) < rxLen[remChan] / 4) mMem[rxB[remChan] + int'(remWordIdx)] = remWdata;
      if (hostValid && hostWrite && !hostCtrlSel && w < 92) mMem[w] = hostWdata;
      nTx = mTx; nRx = mRx;
      if (remAck && int'(remAckChan) < 12) nTx[remAckChan] = 1'b0;
      if (hostValid && hostWrite && hostCtrlSel && hostAddr == 10'h004) nTx = nTx | hostWdata[11:0];
      if (hostValid && hostWrite && hostCtrlSel && hostAddr == 10'h074) nRx = nRx & ~hostWdata[11:0];
      if (remPost && int'(remPostChan) < 12) nRx[remPostChan] = 1'b1;
      mTx = nTx; mRx = nRx;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(hostIrq == (mRx != 0), "R4 R5 irq", {31'h0, hostIrq}, {31'h0, mRx != 0});
      chk(remTxPend == mTx, "R2 R3 txpend", {20'h0, remTxPend}, {20'h0, mTx});
      if (expHostChk) chk(hostRdata == expHost, hostTag, hostRdata, expHost);
      if (expRemChk)  chk(remRdata == expRem, remTag, remRdata, expRem);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; failed++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic idle();
    hostValid = 0; hostWrite = 0; hostCtrlSel = 0; hostAddr = '0; hostWdata = '0;
    remAck = 0; remAckChan = '0; remPost = 0; remPostChan = '0;
    remChan = '0; remWordIdx = '0; remRead = 0; remWrite = 0; remWdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic hWr(input bit ctl, input logic [9:0] a, input logic [31:0] d);
    hostValid = 1; hostWrite = 1; hostCtrlSel = ctl; hostAddr = a; hostWdata = d;
  endtask

  task automatic hRd(input bit ctl, input logic [9:0] a);
    hostValid = 1; hostWrite = 0; hostCtrlSel = ctl; hostAddr = a;
  endtask

  task automatic rRd(input logic [3:0] c, input logic [3:0] k);
    remRead = 1; remChan = c; remWordIdx = k;
  endtask

  task automatic rWr(input logic [3:0] c, input logic [3:0] k, input logic [31:0] d);
    remWrite = 1; remChan = c; remWordIdx = k; remWdata = d;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11: reset state
    chk(hostIrq == 0, "R11 irq", {31'h0, hostIrq}, 0);
    chk(remTxPend == 0, "R11 txpend", {20'h0, remTxPend}, 0);
    curTag = "R11";
    hRd(1, 10'h000); step();
    hRd(1, 10'h078); step();
    hRd(0, 10'h040); step();
    // R6 then R2: fill channel 1 window ascending, ring doorbell
    curTag = "R6";
    for (int i = 0; i < 8; i++) begin hWr(0, 10'(16 + 4 * i), 32'hA000 + i); step(); end
    hRd(0, 10'h014); step();
    curTag = "R2";
    hWr(1, 10'h004, 32'h0000_0002); step();
    hRd(1, 10'h000); step();
    // R7: remote reads of channel 1, index 8 is outside
    curTag = "R7";
    for (int k = 0; k < 9; k++) begin rRd(4'd1, 4'(k)); step(); end
    rRd(4'd8, 4'd1); step();
    curTag = "R3";
    remAck = 1; remAckChan = 4'd1; step();
    hRd(1, 10'h000); step();
    // R2: zero bits leave channels alone
    curTag = "R2";
    hWr(1, 10'h004, 32'h0000_0005); step();
    hWr(1, 10'h004, 32'hFFFF_F800); step();
    hRd(1, 10'h000); step();
    // R3: set wins over ack in the same cycle
    curTag = "R3";
    hWr(1, 10'h004, 32'h1); remAck = 1; remAckChan = 4'd0; step();
    hRd(1, 10'h000); step();
    for (int c = 0; c < 12; c++) begin remAck = 1; remAckChan = 4'(c); step(); end
    hRd(1, 10'h000); step();
    // R8: remote fills channel 7 incoming window, index 6 is outside
    curTag = "R8";
    hWr(0, 10'h148, 32'h5A5A_5A5A); step();
    for (int k = 0; k < 7; k++) begin rWr(4'd7, 4'(k), 32'hB700 + k); step(); end
    for (int a = 10'h130; a <= 10'h148; a += 4) begin hRd(0, 10'(a)); step(); end
    // R4: post raises interrupt
    curTag = "R4";
    remPost = 1; remPostChan = 4'd7; step();
    hRd(1, 10'h078); step();
    // R5: zero bits no effect; post beats clear; full clear
    curTag = "R5";
    hWr(1, 10'h074, 32'h0000_0F7F); step();
    hRd(1, 10'h078); step();
    hWr(1, 10'h074, 32'h0000_0008); remPost = 1; remPostChan = 4'd3; step();
    hRd(1, 10'h078); step();
    hWr(1, 10'h074, 32'h0000_0FFF); step();
    hRd(1, 10'h078); step();
    // R9: unused channel codes
    curTag = "R9";
    remPost = 1; remPostChan = 4'd12; step();
    remPost = 1; remPostChan = 4'd15; step();
    hWr(1, 10'h004, 32'h10); step();
    remAck = 1; remAckChan = 4'd13; step();
    rRd(4'd14, 4'd0); step();
    rWr(4'd12, 4'd0, 32'hDEAD_BEEF); step();
    hRd(0, 10'h000); step();
    hRd(0, 10'h0E0); step();
    hRd(1, 10'h078); step();
    hRd(1, 10'h000); step();
    // R6: out of range words and ignored low address bits
    curTag = "R6";
    hWr(0, 10'h170, 32'hDEAD_0001); step();
    hRd(0, 10'h170); step();
    hWr(0, 10'h3FC, 32'hDEAD_0002); step();
    hRd(0, 10'h16C); step();
    hWr(0, 10'h0E3, 32'h1234_5678); step();
    hRd(0, 10'h0E0); step();
    // R1: unmapped and write-only offsets
    curTag = "R1";
    hWr(1, 10'h008, 32'hFFFF_FFFF); step();
    hWr(1, 10'h005, 32'hFFFF_FFFF); step();
    hRd(1, 10'h004); step();
    hRd(1, 10'h074); step();
    hRd(1, 10'h008); step();
    hRd(1, 10'h07C); step();
    hRd(1, 10'h000); step();
    // R10: host and remote hit the same word
    curTag = "R10";
    hWr(0, 10'h0E0, 32'hCAFE_0000); rWr(4'd0, 4'd0, 32'hBAD0_0000); step();
    hRd(0, 10'h0E0); step();
    // Random mix, model checks every cycle
    curTag = "R6 R7 random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 1) == 1) begin
        if ($urandom_range(0, 2) == 0) hRd($urandom_range(0, 1) == 1, 10'($urandom_range(0, 1023)));
        else if ($urandom_range(0, 1) == 1) hRd(0, 10'($urandom_range(0, 400)));
        else if ($urandom_range(0, 1) == 1) hWr(1, ($urandom_range(0, 1) == 1) ? 10'h004 : 10'h074, $urandom);
        else hWr(0, 10'($urandom_range(0, 400)), $urandom);
      end
      if ($urandom_range(0, 3) == 0) begin remAck = 1; remAckChan = 4'($urandom_range(0, 15)); end
      if ($urandom_range(0, 3) == 0) begin remPost = 1; remPostChan = 4'($urandom_range(0, 15)); end
      if ($urandom_range(0, 2) == 0) begin
        remChan = 4'($urandom_range(0, 13)); remWordIdx = 4'($urandom_range(0, 9));
        remRead = 1'($urandom_range(0, 1)); remWrite = 1'($urandom_range(0, 1));
        remWdata = $urandom;
      end
      step();
    end
    repeat (2) step();
    summary();
  end

endmodule